// File: doc/BRIEF.md
# Processor State and Exception-Entry Controller

This block is the top-level state sequencer of a small 32-bit CPU core. It keeps the core in one of five states: reset, exception handling, program execution, power-down and bus released. It decides when the program counter is loaded and with which address. It captures the interrupted context into three shadow registers on exception entry. It reports which register domains a reset has to initialise, and it grants the external bus to another master.

Two kinds of reset exist. A power-on reset clears every domain. A manual reset spares the bus-controller domain, so memory refresh keeps running through it. A general exception, an interrupt, or a wake-up from power-down passes through a short fixed-length exception-handling state. That state saves the program counter, status register and R15. It then vectors to the vector base plus the offset supplied with the request.

Top module: `cpu_state_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the next cycle shows `state_o` = 0 (reset), `init_core_o` = 1, `bus_grant_o` = 0 and `pc_load_o` = 0, whatever the previous state was. The state codes are 0 reset, 1 exception handling, 2 program execution, 3 power-down and 4 bus released.
- R2: `last_por_o` takes the value of `rst_por_i` sampled during reset, where 1 means power-on and 0 means manual. `init_bus_o` is 1 in the reset state only after a power-on reset, and 0 after a manual reset.
- R3: At the first edge with `rst_n` high while in reset, the block enters program execution. In that cycle `pc_load_o` pulses for exactly one cycle with `pc_value_o` = 0xA000_0000.
- R4: When a request is accepted, the next cycle shows state 1 and a one-cycle `save_o` pulse. From then on `spc_o`, `ssr_o` and `sgr_o` hold the `pc_i`, `sr_i` and `r15_i` values of the accepting cycle until the next acceptance.
- R5: The exception-handling state lasts exactly EXC_CYCLES cycles (default 2). It then returns to program execution with a one-cycle `pc_load_o` pulse. `pc_value_o` equals `vbr_i` plus the zero-extended `evt_offset_i`, both sampled in the accepting cycle.
- R6: In program execution, simultaneous requests are served in a fixed order: `evt_req_i` first, then `bus_req_i`, then `sleep_req_i`.
- R7: A sleep request in program execution enters power-down (state 3). `pd_standby_o` shows the `standby_i` value sampled with the request, where 1 means standby and 0 means sleep, and it reads 0 outside power-down.
- R8: In power-down, `wake_i` leads to exception entry with the saves of R4 and the vector of R5. `evt_req_i`, `bus_req_i` and `sleep_req_i` have no effect there.
- R9: A bus request in program execution enters bus released (state 4) with `bus_grant_o` = 1. The block stays there while the request is held, ignoring `evt_req_i` and `sleep_req_i`. It returns to program execution with the grant dropped the cycle after the request is withdrawn.
- R10: During exception handling, `evt_req_i`, `bus_req_i` and `sleep_req_i` are ignored. The state always ends in program execution unless reset intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset request, sampled synchronously |
| rst_por_i | input | 1 | Reset kind during reset: 1 power-on, 0 manual |
| evt_req_i | input | 1 | General exception or interrupt request |
| evt_offset_i | input | OFF_W | Vector offset of the request or of the wake-up |
| vbr_i | input | 32 | Vector base address |
| pc_i | input | DATA_W | Current program counter, to be saved |
| sr_i | input | DATA_W | Current status register, to be saved |
| r15_i | input | DATA_W | Current R15, to be saved |
| sleep_req_i | input | 1 | Sleep instruction executed |
| standby_i | input | 1 | Power-down mode with the sleep request: 1 standby, 0 sleep |
| wake_i | input | 1 | Wake-up interrupt while in power-down |
| bus_req_i | input | 1 | External bus request |
| state_o | output | 3 | Current state code |
| init_core_o | output | 1 | Initialise CPU and peripheral domains |
| init_bus_o | output | 1 | Initialise the bus-controller domain |
| last_por_o | output | 1 | Kind of the last reset: 1 power-on |
| pd_standby_o | output | 1 | Active power-down mode: 1 standby |
| pc_load_o | output | 1 | One-cycle program counter load strobe |
| pc_value_o | output | 32 | Address to load into the program counter |
| save_o | output | 1 | One-cycle strobe: shadows were just written |
| spc_o | output | DATA_W | Saved program counter |
| ssr_o | output | DATA_W | Saved status register |
| sgr_o | output | DATA_W | Saved R15 |
| bus_grant_o | output | 1 | Bus granted to the external master |

## Verification
A wrong internal state appears on `state_o` in the very next cycle. It is also visible one cycle later as a missing or spurious `pc_load_o`, `save_o` or `bus_grant_o`. An exception-length counter that is off by one moves the vector load by a cycle, which a check at exactly EXC_CYCLES cycles after acceptance catches. A wrongly latched offset, base or context value stays visible on `pc_value_o` or the shadow outputs until the next load. A mis-captured reset kind shows on `init_bus_o` from the first reset cycle.

// File: rtl/cpu_state_pkg.sv
// Shared state encoding and constants of the processor state sequencer.
package cpu_state_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_EXC    = 3'd1,
        ST_RUN    = 3'd2,
        ST_PDOWN  = 3'd3,
        ST_BUSREL = 3'd4
    } cpu_state_e;

    localparam logic [31:0] RESET_VECTOR = 32'hA000_0000;
endpackage

// File: rtl/cpu_state_fsm.sv
// State register and transition logic of the sequencer.
// Assumes rst_n is synchronous; the reset kind is captured while it is low.
// Exception handling lasts EXC_CYCLES cycles (EXC_CYCLES >= 1).
module cpu_state_fsm
    import cpu_state_pkg::*;
#(
    parameter int EXC_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_por_i,
    input  logic       evt_req_i,
    input  logic       sleep_req_i,
    input  logic       standby_i,
    input  logic       bus_req_i,
    input  logic       wake_i,
    output cpu_state_e state_o,
    output logic       enter_exc_o,
    output logic       exit_exc_o,
    output logic       exit_reset_o,
    output logic       last_por_o,
    output logic       pd_standby_o
);
    localparam int CNT_W = (EXC_CYCLES > 1) ? $clog2(EXC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXC_CYCLES - 1);

    cpu_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next state with fixed request priority in program execution.
    always_comb begin
        state_d      = state_q;
        enter_exc_o  = 1'b0;
        exit_exc_o   = 1'b0;
        exit_reset_o = 1'b0;
        case (state_q)
            ST_RESET: begin
                state_d      = ST_RUN;
                exit_reset_o = 1'b1;
            end
            ST_EXC: begin
                if (cnt_q == CNT_LAST) begin
                    state_d    = ST_RUN;
                    exit_exc_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (evt_req_i) begin
                    state_d     = ST_EXC;
                    enter_exc_o = 1'b1;
                end else if (bus_req_i) begin
                    state_d = ST_BUSREL;
                end else if (sleep_req_i) begin
                    state_d = ST_PDOWN;
                end
            end
            ST_PDOWN: begin
                if (wake_i) begin
                    state_d     = ST_EXC;
                    enter_exc_o = 1'b1;
                end
            end
            ST_BUSREL: begin
                if (!bus_req_i) state_d = ST_RUN;
            end
            default: state_d = ST_RESET;
        endcase
    end

    // State, exception cycle counter, reset kind and power-down mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RESET;
            cnt_q        <= '0;
            last_por_o   <= rst_por_i;
            pd_standby_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_EXC && !exit_exc_o) cnt_q <= cnt_q + CNT_W'(1);
            else                                  cnt_q <= '0;
            if (state_q == ST_RUN && state_d == ST_PDOWN)      pd_standby_o <= standby_i;
            else if (state_q == ST_PDOWN && state_d != ST_PDOWN) pd_standby_o <= 1'b0;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/cpu_pc_gen.sv
// Program counter load generator: reset vector on reset exit,
// vector base plus offset (captured at acceptance) on exception exit.
// Assumes OFF_W < 32.
module cpu_pc_gen
    import cpu_state_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_exc_i,
    input  logic             exit_exc_i,
    input  logic             exit_reset_i,
    input  logic [31:0]      vbr_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic             pc_load_o,
    output logic [31:0]      pc_value_o
);
    localparam int PAD_W = 32 - OFF_W;

    logic [31:0] target_q;

    // Capture the vector target and drive the one-cycle load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q   <= '0;
            pc_load_o  <= 1'b0;
            pc_value_o <= '0;
        end else begin
            if (enter_exc_i) target_q <= vbr_i + {{PAD_W{1'b0}}, offset_i};
            pc_load_o <= exit_reset_i | exit_exc_i;
            if (exit_reset_i)    pc_value_o <= RESET_VECTOR;
            else if (exit_exc_i) pc_value_o <= target_q;
        end
    end
endmodule

// File: rtl/cpu_shadow_bank.sv
// Shadow registers for PC, SR and R15, written together on exception entry.
// Assumes save_i is a single-cycle pulse from the sequencer.
module cpu_shadow_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [DATA_W-1:0] r15_i,
    output logic              saved_o,
    output logic [DATA_W-1:0] spc_o,
    output logic [DATA_W-1:0] ssr_o,
    output logic [DATA_W-1:0] sgr_o
);
    localparam int NUM_SHD = 3;

    logic [DATA_W-1:0] src [NUM_SHD];
    logic [DATA_W-1:0] shd [NUM_SHD];

    assign src[0] = pc_i;
    assign src[1] = sr_i;
    assign src[2] = r15_i;

    for (genvar g = 0; g < NUM_SHD; g++) begin : g_shd
        // One shadow entry, loaded on the save pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)      shd[g] <= '0;
            else if (save_i) shd[g] <= src[g];
        end
    end

    // Strobe telling that the shadows were written at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) saved_o <= 1'b0;
        else        saved_o <= save_i;
    end

    assign spc_o = shd[0];
    assign ssr_o = shd[1];
    assign sgr_o = shd[2];
endmodule

// File: rtl/cpu_state_seq.sv
// Top of the processor state sequencer: state machine, PC load
// generator and shadow bank, plus domain-select and grant decode.
// Assumes all inputs are synchronous to clk.
module cpu_state_seq
    import cpu_state_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 16,
    parameter int EXC_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_por_i,
    input  logic              evt_req_i,
    input  logic [OFF_W-1:0]  evt_offset_i,
    input  logic [31:0]       vbr_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [DATA_W-1:0] r15_i,
    input  logic              sleep_req_i,
    input  logic              standby_i,
    input  logic              wake_i,
    input  logic              bus_req_i,
    output logic [2:0]        state_o,
    output logic              init_core_o,
    output logic              init_bus_o,
    output logic              last_por_o,
    output logic              pd_standby_o,
    output logic              pc_load_o,
    output logic [31:0]       pc_value_o,
    output logic              save_o,
    output logic [DATA_W-1:0] spc_o,
    output logic [DATA_W-1:0] ssr_o,
    output logic [DATA_W-1:0] sgr_o,
    output logic              bus_grant_o
);
    cpu_state_e state;
    logic       enter_exc, exit_exc, exit_reset;

    cpu_state_fsm #(.EXC_CYCLES(EXC_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_por_i    (rst_por_i),
        .evt_req_i    (evt_req_i),
        .sleep_req_i  (sleep_req_i),
        .standby_i    (standby_i),
        .bus_req_i    (bus_req_i),
        .wake_i       (wake_i),
        .state_o      (state),
        .enter_exc_o  (enter_exc),
        .exit_exc_o   (exit_exc),
        .exit_reset_o (exit_reset),
        .last_por_o   (last_por_o),
        .pd_standby_o (pd_standby_o)
    );

    cpu_pc_gen #(.OFF_W(OFF_W)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_exc_i  (enter_exc),
        .exit_exc_i   (exit_exc),
        .exit_reset_i (exit_reset),
        .vbr_i        (vbr_i),
        .offset_i     (evt_offset_i),
        .pc_load_o    (pc_load_o),
        .pc_value_o   (pc_value_o)
    );

    cpu_shadow_bank #(.DATA_W(DATA_W)) u_shd (
        .clk     (clk),
        .rst_n   (rst_n),
        .save_i  (enter_exc),
        .pc_i    (pc_i),
        .sr_i    (sr_i),
        .r15_i   (r15_i),
        .saved_o (save_o),
        .spc_o   (spc_o),
        .ssr_o   (ssr_o),
        .sgr_o   (sgr_o)
    );

    // Domain selects and grant decoded from the current state.
    always_comb begin
        state_o     = state;
        init_core_o = (state == ST_RESET);
        init_bus_o  = (state == ST_RESET) && last_por_o;
        bus_grant_o = (state == ST_BUSREL);
    end
endmodule

// File: rtl/cpu_state_seq_chk.sv
// Property checker for the processor state sequencer, bound to its top.
module cpu_state_seq_chk
    import cpu_state_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  state_o,
    input logic        pc_load_o,
    input logic [31:0] pc_value_o,
    input logic        save_o,
    input logic        bus_grant_o,
    input logic        bus_req_i,
    input logic        wake_i,
    input logic        pd_standby_o,
    input logic        init_bus_o,
    input logic        last_por_o
);
    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    p_bus_init_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_bus_o |-> last_por_o);

    p_pc_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    p_reset_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && $past(state_o) == ST_RESET) |-> pc_value_o == RESET_VECTOR);

    p_save_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |-> (state_o == ST_EXC && $past(state_o) != ST_EXC));

    p_exc_exits_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_EXC |=> (state_o == ST_EXC || state_o == ST_RUN));

    p_standby_only_pdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != ST_PDOWN |-> !pd_standby_o);

    p_wake_enters_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PDOWN && wake_i) |=> state_o == ST_EXC);

    p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> $past(bus_req_i));

    p_grant_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant_o && bus_req_i) |=> bus_grant_o);
endmodule

bind cpu_state_seq cpu_state_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_o      (state_o),
    .pc_load_o    (pc_load_o),
    .pc_value_o   (pc_value_o),
    .save_o       (save_o),
    .bus_grant_o  (bus_grant_o),
    .bus_req_i    (bus_req_i),
    .wake_i       (wake_i),
    .pd_standby_o (pd_standby_o),
    .init_bus_o   (init_bus_o),
    .last_por_o   (last_por_o)
);

// File: tb/cpu_state_seq_test.sv
// Directed bench for the processor state sequencer.
module cpu_state_seq_test;
    logic        clk = 1'b0;
    logic        rst_n, rst_por_i, evt_req_i, sleep_req_i, standby_i, wake_i, bus_req_i;
    logic [15:0] evt_offset_i;
    logic [31:0] vbr_i, pc_i, sr_i, r15_i;
    logic [2:0]  state_o;
    logic        init_core_o, init_bus_o, last_por_o, pd_standby_o, pc_load_o, save_o, bus_grant_o;
    logic [31:0] pc_value_o, spc_o, ssr_o, sgr_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cpu_state_seq uut (
        .clk(clk), .rst_n(rst_n), .rst_por_i(rst_por_i), .evt_req_i(evt_req_i),
        .evt_offset_i(evt_offset_i), .vbr_i(vbr_i), .pc_i(pc_i), .sr_i(sr_i),
        .r15_i(r15_i), .sleep_req_i(sleep_req_i), .standby_i(standby_i),
        .wake_i(wake_i), .bus_req_i(bus_req_i), .state_o(state_o),
        .init_core_o(init_core_o), .init_bus_o(init_bus_o), .last_por_o(last_por_o),
        .pd_standby_o(pd_standby_o), .pc_load_o(pc_load_o), .pc_value_o(pc_value_o),
        .save_o(save_o), .spc_o(spc_o), .ssr_o(ssr_o), .sgr_o(sgr_o),
        .bus_grant_o(bus_grant_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic t_power_on_reset();
        rst_n = 1'b0; rst_por_i = 1'b1;
        tick(); tick();
        check("R1", "state in reset", 32'(state_o), 32'd0);
        check("R1", "init_core", 32'(init_core_o), 32'd1);
        check("R1", "grant in reset", 32'(bus_grant_o), 32'd0);
        check("R1", "pc_load in reset", 32'(pc_load_o), 32'd0);
        check("R2", "last_por power-on", 32'(last_por_o), 32'd1);
        check("R2", "init_bus power-on", 32'(init_bus_o), 32'd1);
        rst_n = 1'b1;
        tick();
        check("R3", "state after release", 32'(state_o), 32'd2);
        check("R3", "pc_load after release", 32'(pc_load_o), 32'd1);
        check("R3", "reset vector", pc_value_o, 32'hA000_0000);
        tick();
        check("R3", "pc_load one cycle", 32'(pc_load_o), 32'd0);
    endtask

    task automatic t_exception_priority();
        pc_i = 32'h1111_0000; sr_i = 32'h2222_0000; r15_i = 32'h3333_0000;
        vbr_i = 32'h8000_0000; evt_offset_i = 16'h0100;
        evt_req_i = 1'b1; bus_req_i = 1'b1; sleep_req_i = 1'b1;
        tick();
        check("R6", "event wins over bus and sleep", 32'(state_o), 32'd1);
        check("R4", "save pulse", 32'(save_o), 32'd1);
        check("R4", "spc", spc_o, 32'h1111_0000);
        check("R4", "ssr", ssr_o, 32'h2222_0000);
        check("R4", "sgr", sgr_o, 32'h3333_0000);
        pc_i = 32'hDEAD_0001; sr_i = 32'hDEAD_0002; r15_i = 32'hDEAD_0003;
        vbr_i = 32'h0000_0000; evt_offset_i = 16'h0FF0;
        tick();
        check("R10", "still in exception, requests ignored", 32'(state_o), 32'd1);
        check("R4", "save pulse one cycle", 32'(save_o), 32'd0);
        evt_req_i = 1'b0; bus_req_i = 1'b0; sleep_req_i = 1'b0;
        tick();
        check("R5", "back to execution", 32'(state_o), 32'd2);
        check("R5", "vector load", 32'(pc_load_o), 32'd1);
        check("R5", "vector address", pc_value_o, 32'h8000_0100);
        check("R4", "spc kept", spc_o, 32'h1111_0000);
        check("R4", "sgr kept", sgr_o, 32'h3333_0000);
        tick();
    endtask

    task automatic t_bus_release();
        bus_req_i = 1'b1; sleep_req_i = 1'b1;
        tick();
        check("R6", "bus wins over sleep", 32'(state_o), 32'd4);
        check("R9", "grant", 32'(bus_grant_o), 32'd1);
        sleep_req_i = 1'b0; evt_req_i = 1'b1;
        tick();
        check("R9", "event ignored while released", 32'(state_o), 32'd4);
        check("R9", "no save while released", 32'(save_o), 32'd0);
        evt_req_i = 1'b0; bus_req_i = 1'b0;
        tick();
        check("R9", "return to execution", 32'(state_o), 32'd2);
        check("R9", "grant dropped", 32'(bus_grant_o), 32'd0);
    endtask

    task automatic t_standby_and_wake();
        sleep_req_i = 1'b1; standby_i = 1'b1;
        tick();
        check("R7", "power-down", 32'(state_o), 32'd3);
        check("R7", "standby mode", 32'(pd_standby_o), 32'd1);
        sleep_req_i = 1'b0; standby_i = 1'b0; bus_req_i = 1'b1; evt_req_i = 1'b1;
        tick();
        check("R8", "requests ignored in power-down", 32'(state_o), 32'd3);
        check("R8", "no grant in power-down", 32'(bus_grant_o), 32'd0);
        check("R7", "mode held", 32'(pd_standby_o), 32'd1);
        bus_req_i = 1'b0; evt_req_i = 1'b0;
        pc_i = 32'h0000_5555; vbr_i = 32'h8000_0000; evt_offset_i = 16'h0040;
        wake_i = 1'b1;
        tick();
        check("R8", "wake enters exception", 32'(state_o), 32'd1);
        check("R8", "wake saves pc", spc_o, 32'h0000_5555);
        check("R7", "mode cleared outside power-down", 32'(pd_standby_o), 32'd0);
        wake_i = 1'b0;
        tick(); tick();
        check("R8", "wake vector", pc_value_o, 32'h8000_0040);
        check("R8", "running after wake", 32'(state_o), 32'd2);
    endtask

    task automatic t_sleep_mode();
        sleep_req_i = 1'b1; standby_i = 1'b0;
        tick();
        sleep_req_i = 1'b0;
        check("R7", "sleep mode power-down", 32'(state_o), 32'd3);
        check("R7", "sleep mode flag", 32'(pd_standby_o), 32'd0);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        tick(); tick();
        check("R8", "running after sleep wake", 32'(state_o), 32'd2);
    endtask

    task automatic t_manual_reset_from_exc();
        evt_req_i = 1'b1;
        tick();
        evt_req_i = 1'b0;
        check("R4", "entered exception", 32'(state_o), 32'd1);
        rst_n = 1'b0; rst_por_i = 1'b0;
        tick();
        check("R1", "reset overrides exception", 32'(state_o), 32'd0);
        check("R1", "no vector load in reset", 32'(pc_load_o), 32'd0);
        check("R2", "last_por manual", 32'(last_por_o), 32'd0);
        check("R2", "bus domain spared", 32'(init_bus_o), 32'd0);
        check("R1", "core domain init", 32'(init_core_o), 32'd1);
        rst_n = 1'b1; rst_por_i = 1'b1;
        tick();
        check("R3", "manual reset exit vector", pc_value_o, 32'hA000_0000);
        check("R2", "kind kept after release", 32'(last_por_o), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; rst_por_i = 1'b1; evt_req_i = 1'b0; sleep_req_i = 1'b0;
        standby_i = 1'b0; wake_i = 1'b0; bus_req_i = 1'b0; evt_offset_i = '0;
        vbr_i = '0; pc_i = '0; sr_i = '0; r15_i = '0;
        t_power_on_reset();
        t_exception_priority();
        t_bus_release();
        t_standby_and_wake();
        t_sleep_mode();
        t_manual_reset_from_exc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule